// File: doc/BRIEF.md
# Register Transfer and Exchange Sequencer

This block is the control and storage slice of a small 8/16-bit processor's register file. It carries out two register-to-register moves. A transfer copies one register into another. An exchange swaps two registers. Both moves use one 16-bit internal bus with a single read port and a single write port, plus one internal holding register. Every move is split into fixed two-cycle phases. The first two cycles stand in for instruction fetch. Next, the source value is captured in the holding register. The remaining phases then perform the writes.

The sequence length depends only on the kind of move, never on register width. An 8-bit pair takes as long as a 16-bit pair. Byte registers are widened on the bus with an all-ones upper byte and take only the low byte when written. The 16-bit accumulator is stored as its two byte halves, so the halves and the whole always agree. A one-cycle done pulse tells the surrounding core that the move has finished.

Top module: `regxfer_seq`

## Requirements
- R1: During and after reset, busy_o and done_o are 0. The registers hold their reset parameters: X=A1B2, Y=C3D4, U=E5F6, S=0718, PC=293A, A=12, B=34, flags=56, page=78 (hex).
- R2: A start_i sampled high while idle makes busy_o high from the next cycle. busy_o stays high for exactly 6 cycles for a transfer (xchg_i=0) and 8 cycles for an exchange (xchg_i=1), for 8-bit and 16-bit codes alike.
- R3: A transfer leaves every register unchanged until the edge that ends cycle 6. At that edge the destination receives the source value that was captured at the end of cycle 4. No register changes while busy_o is low.
- R4: An exchange writes the old destination value into the source register at the end of cycle 6. It then writes the old source value into the destination register at the end of cycle 8.
- R5: The 4-bit register codes are: 0=D, 1=X, 2=Y, 3=U, 4=S, 5=PC, 8=A, 9=B, 10=flags, 11=page.
- R6: An 8-bit register read onto the bus appears as {8'hFF, value}. An 8-bit register written from the bus takes bits [7:0].
- R7: D reads as {A, B}. Writing D loads A from bits [15:8] and B from bits [7:0]. Writing A or B changes the matching half of D.
- R8: Codes 6, 7 and 12 to 15 read as 16'hFFFF. Writes to those codes change no register.
- R9: A start_i that arrives while busy_o is high is ignored. The running move keeps its latched codes, its kind and its length, and no second move follows.
- R10: done_o is high for exactly one cycle: the cycle right after the final write edge, which is also the first cycle with busy_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a move |
| xchg_i | input | 1 | Move kind: 0 transfer, 1 exchange |
| src_code_i | input | 4 | Source register code (first register of an exchange) |
| dst_code_i | input | 4 | Destination register code (second register of an exchange) |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle completion pulse |
| acc_a_o | output | 8 | Accumulator A (high half of D) |
| acc_b_o | output | 8 | Accumulator B (low half of D) |
| flags_o | output | 8 | Flags register |
| page_o | output | 8 | Direct page register |
| idx_x_o | output | 16 | Index register X |
| idx_y_o | output | 16 | Index register Y |
| usp_o | output | 16 | User stack pointer |
| ssp_o | output | 16 | System stack pointer |
| pc_o | output | 16 | Program counter |

## Verification
The assertions check on every cycle that the phase counter stays inside the length of the running move and that latched codes cannot change under a late start. They also check that done is a lone pulse following the last busy cycle, that no register moves while idle, that writes to undefined codes leave everything alone, and that a write to D splits into A and B. Only the bench's scenarios can show the values that actually land. This covers the all-ones widening of byte registers, the order of the two exchange writes as seen in the cycle between them, the 0xFFFF read of an undefined code, and the equal length of 8-bit and 16-bit moves.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int N_WIDE = 5;
  localparam int N_BYTE = 4;
  localparam int CODE_W = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [N_WIDE-1:0][WORD_W-1:0] wide_vec_t;
  typedef logic [N_BYTE-1:0][BYTE_W-1:0] byte_vec_t;

  localparam code_t CODE_D       = 4'd0;
  localparam code_t CODE_WIDE_LO = 4'd1;
  localparam code_t CODE_WIDE_HI = 4'd5;
  localparam code_t CODE_BYTE_LO = 4'd8;
  localparam code_t CODE_BYTE_HI = 4'd11;

  function automatic logic is_wide_code(code_t c);
    return (c >= CODE_WIDE_LO) && (c <= CODE_WIDE_HI);
  endfunction

  function automatic logic is_byte_code(code_t c);
    return (c >= CODE_BYTE_LO) && (c <= CODE_BYTE_HI);
  endfunction

  function automatic logic code_valid(code_t c);
    return (c == CODE_D) || is_wide_code(c) || is_byte_code(c);
  endfunction

  function automatic word_t widen_byte(byte_t b);
    return {8'hFF, b};
  endfunction

  function automatic word_t bus_read(code_t c, wide_vec_t w, byte_vec_t b);
    if (c == CODE_D)      return {b[0], b[1]};
    if (is_wide_code(c))  return w[3'(c - CODE_WIDE_LO)];
    if (is_byte_code(c))  return widen_byte(b[2'(c - CODE_BYTE_LO)]);
    return 16'hFFFF;
  endfunction

endpackage

// File: rtl/regxfer_ctrl.sv
module regxfer_ctrl
  import regxfer_pkg::*;
#(
  parameter int FETCH_CYC = 2,
  parameter int PHASE_CYC = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  xchg_i,
  input  code_t src_i,
  input  code_t dst_i,
  output logic  busy_o,
  output logic  done_o,
  output logic  tmp_ld_o,
  output logic  wr_a_o,
  output logic  wr_b_o,
  output logic  xchg_q_o,
  output code_t src_q_o,
  output code_t dst_q_o
);

  localparam int LOAD_END = FETCH_CYC + PHASE_CYC;
  localparam int WR1_END  = LOAD_END + PHASE_CYC;
  localparam int WR2_END  = WR1_END + PHASE_CYC;
  localparam int CNT_W    = $clog2(WR2_END + 1);

  localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(LOAD_END);
  localparam logic [CNT_W-1:0] WR1_C  = CNT_W'(WR1_END);
  localparam logic [CNT_W-1:0] WR2_C  = CNT_W'(WR2_END);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, xchg_q;
  code_t            src_q, dst_q;
  logic             accept;
  logic [CNT_W-1:0] last_c;
  logic             at_last;

  assign accept  = start_i && !busy_q;
  assign last_c  = xchg_q ? WR2_C : WR1_C;
  assign at_last = busy_q && (cnt_q == last_c);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      xchg_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= ONE_C;
        xchg_q <= xchg_i;
        src_q  <= src_i;
        dst_q  <= dst_i;
      end else if (at_last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q + ONE_C;
      end
    end
  end

  assign tmp_ld_o = busy_q && (cnt_q == LOAD_C);
  assign wr_a_o   = busy_q && (cnt_q == WR1_C);
  assign wr_b_o   = busy_q && xchg_q && (cnt_q == WR2_C);
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign xchg_q_o = xchg_q;
  assign src_q_o  = src_q;
  assign dst_q_o  = dst_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q >= ONE_C) && (cnt_q <= last_c)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q))); // R10
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_last) |=> (busy_q && $stable(src_q) && $stable(dst_q) && $stable(xchg_q))); // R9

endmodule

// File: rtl/regxfer_regfile.sv
module regxfer_regfile
  import regxfer_pkg::*;
#(
  parameter wide_vec_t RST_WIDE = '0,
  parameter byte_vec_t RST_BYTE = '0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  code_t     wr_code,
  input  word_t     wr_data,
  input  code_t     rd_code,
  output word_t     rd_data,
  output wide_vec_t wide_q,
  output byte_vec_t byte_q
);

  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    localparam code_t OWN = code_t'(i + 1);
    word_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        q <= RST_WIDE[i];
      else if (wr_en && wr_code == OWN)  q <= wr_data;
    end
    assign wide_q[i] = q;
  end

  for (genvar j = 0; j < N_BYTE; j++) begin : g_byte
    localparam code_t OWN  = code_t'(8 + j);
    localparam bit    IN_D = (j < 2);
    localparam bit    IS_HI = (j == 0);
    byte_t q;
    logic  hit_own, hit_d;
    assign hit_own = wr_en && (wr_code == OWN);
    assign hit_d   = IN_D && wr_en && (wr_code == CODE_D);
    always_ff @(posedge clk) begin
      if (!rst_n)       q <= RST_BYTE[j];
      else if (hit_own) q <= wr_data[7:0];
      else if (hit_d)   q <= IS_HI ? wr_data[15:8] : wr_data[7:0];
    end
    assign byte_q[j] = q;
  end

  assign rd_data = bus_read(rd_code, wide_q, byte_q);

  AST_UNDEF_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !code_valid(wr_code)) |=> ($stable(wide_q) && $stable(byte_q))); // R8
  AST_D_SPLITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_code == CODE_D) |=>
      (byte_q[0] == $past(wr_data[15:8]) && byte_q[1] == $past(wr_data[7:0]))); // R7

endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
  import regxfer_pkg::*;
#(
  parameter int        FETCH_CYC = 2,
  parameter int        PHASE_CYC = 2,
  parameter wide_vec_t RST_WIDE  = {16'h293A, 16'h0718, 16'hE5F6, 16'hC3D4, 16'hA1B2},
  parameter byte_vec_t RST_BYTE  = {8'h78, 8'h56, 8'h34, 8'h12}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        xchg_i,
  input  logic [3:0]  src_code_i,
  input  logic [3:0]  dst_code_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  acc_a_o,
  output logic [7:0]  acc_b_o,
  output logic [7:0]  flags_o,
  output logic [7:0]  page_o,
  output logic [15:0] idx_x_o,
  output logic [15:0] idx_y_o,
  output logic [15:0] usp_o,
  output logic [15:0] ssp_o,
  output logic [15:0] pc_o
);

  logic      tmp_ld, wr_a, wr_b, xchg_q;
  code_t     src_q, dst_q;
  code_t     rd_code, wr_code;
  word_t     rd_data, wr_data, tmp_q;
  logic      wr_en;
  wide_vec_t wide_q;
  byte_vec_t byte_q;

  regxfer_ctrl #(.FETCH_CYC(FETCH_CYC), .PHASE_CYC(PHASE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .xchg_i(xchg_i),
    .src_i(src_code_i), .dst_i(dst_code_i),
    .busy_o(busy_o), .done_o(done_o),
    .tmp_ld_o(tmp_ld), .wr_a_o(wr_a), .wr_b_o(wr_b),
    .xchg_q_o(xchg_q), .src_q_o(src_q), .dst_q_o(dst_q)
  );

  // Bus routing: exchange middle phase reads the second register directly.
  assign rd_code = (wr_a && xchg_q) ? dst_q : src_q;
  assign wr_code = (wr_a && xchg_q) ? src_q : dst_q;
  assign wr_data = (wr_a && xchg_q) ? rd_data : tmp_q;
  assign wr_en   = wr_a || wr_b;

  always_ff @(posedge clk) begin
    if (!rst_n)      tmp_q <= '0;
    else if (tmp_ld) tmp_q <= rd_data;
  end

  regxfer_regfile #(.RST_WIDE(RST_WIDE), .RST_BYTE(RST_BYTE)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
    .wr_data(wr_data), .rd_code(rd_code), .rd_data(rd_data),
    .wide_q(wide_q), .byte_q(byte_q)
  );

  assign idx_x_o = wide_q[0];
  assign idx_y_o = wide_q[1];
  assign usp_o   = wide_q[2];
  assign ssp_o   = wide_q[3];
  assign pc_o    = wide_q[4];
  assign acc_a_o = byte_q[0];
  assign acc_b_o = byte_q[1];
  assign flags_o = byte_q[2];
  assign page_o  = byte_q[3];

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> ($stable(wide_q) && $stable(byte_q))); // R3

endmodule

// File: tb/regxfer_seq_tb.sv
`timescale 1ns/1ps
module regxfer_seq_tb;

  typedef struct packed {
    logic [7:0]  a, b, cc, dp;
    logic [15:0] x, y, u, s, pc;
  } model_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, xchg_i = 1'b0;
  logic [3:0] src_code_i = '0, dst_code_i = '0;
  logic busy_o, done_o;
  logic [7:0] acc_a_o, acc_b_o, flags_o, page_o;
  logic [15:0] idx_x_o, idx_y_o, usp_o, ssp_o, pc_o;

  int tests = 0, fails = 0;
  bit finished = 0;
  model_t mdl;

  always #2.5 clk = ~clk;

  regxfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .xchg_i(xchg_i),
    .src_code_i(src_code_i), .dst_code_i(dst_code_i),
    .busy_o(busy_o), .done_o(done_o),
    .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .flags_o(flags_o), .page_o(page_o),
    .idx_x_o(idx_x_o), .idx_y_o(idx_y_o), .usp_o(usp_o), .ssp_o(ssp_o), .pc_o(pc_o)
  );

  function automatic logic [15:0] m_read(model_t m, logic [3:0] c);
    case (c)
      4'd0:  return {m.a, m.b};
      4'd1:  return m.x;
      4'd2:  return m.y;
      4'd3:  return m.u;
      4'd4:  return m.s;
      4'd5:  return m.pc;
      4'd8:  return {8'hFF, m.a};
      4'd9:  return {8'hFF, m.b};
      4'd10: return {8'hFF, m.cc};
      4'd11: return {8'hFF, m.dp};
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic model_t m_write(model_t m, logic [3:0] c, logic [15:0] v);
    model_t r = m;
    case (c)
      4'd0:  begin r.a = v[15:8]; r.b = v[7:0]; end
      4'd1:  r.x = v;
      4'd2:  r.y = v;
      4'd3:  r.u = v;
      4'd4:  r.s = v;
      4'd5:  r.pc = v;
      4'd8:  r.a = v[7:0];
      4'd9:  r.b = v[7:0];
      4'd10: r.cc = v[7:0];
      4'd11: r.dp = v[7:0];
      default: ;
    endcase
    return r;
  endfunction

  function automatic model_t observe();
    model_t o;
    o.a = acc_a_o; o.b = acc_b_o; o.cc = flags_o; o.dp = page_o;
    o.x = idx_x_o; o.y = idx_y_o; o.u = usp_o; o.s = ssp_o; o.pc = pc_o;
    return o;
  endfunction

  task automatic chk(string req, string what, logic [111:0] act, logic [111:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // One move; poke drives a stray start in cycle 3 to show it is ignored.
  task automatic run_op(bit xchg, logic [3:0] s, logic [3:0] d, bit poke, string req);
    model_t pre, mid, fin;
    logic [15:0] t;
    int cnt;
    pre = mdl;
    t = m_read(pre, s);
    if (xchg) begin
      mid = m_write(pre, s, m_read(pre, d));
      fin = m_write(mid, d, t);
    end else begin
      mid = pre;
      fin = m_write(pre, d, t);
    end
    @(negedge clk);
    start_i = 1'b1; xchg_i = xchg; src_code_i = s; dst_code_i = d;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    while (busy_o && cnt < 20) begin
      cnt++;
      if (poke && cnt == 3) begin
        start_i = 1'b1; xchg_i = ~xchg; src_code_i = 4'd1; dst_code_i = 4'd2;
      end
      if (poke && cnt == 4) begin
        start_i = 1'b0; xchg_i = xchg; src_code_i = s; dst_code_i = d;
      end
      if (cnt == 4) chk("R3", {req, " untouched before capture"}, observe(), pre);
      if (!xchg && cnt == 6) chk("R3", {req, " dest unchanged in cycle 6"}, observe(), pre);
      if (xchg && cnt == 7) chk("R4", {req, " first write only"}, observe(), mid);
      @(negedge clk);
    end
    chk("R2", {req, " busy length"}, 112'(cnt), 112'(xchg ? 8 : 6));
    chk("R10", {req, " done after last write"}, 112'({busy_o, done_o}), 112'(2'b01));
    chk(req, {req, " final registers"}, observe(), fin);
    mdl = fin;
    @(negedge clk);
    chk("R10", {req, " done single cycle"}, 112'(done_o), 112'(0));
    chk("R9", {req, " no follow-on move"}, 112'(busy_o), 112'(0));
  endtask

  task automatic t_reset();
    mdl = '{a:8'h12, b:8'h34, cc:8'h56, dp:8'h78,
            x:16'hA1B2, y:16'hC3D4, u:16'hE5F6, s:16'h0718, pc:16'h293A};
    chk("R1", "busy/done in reset", 112'({busy_o, done_o}), 112'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy/done after reset", 112'({busy_o, done_o}), 112'(0));
    chk("R1", "reset register values", observe(), mdl);
  endtask

  task automatic t_wide_xfer();
    run_op(1'b0, 4'd1, 4'd2, 1'b0, "R3");           // X -> Y
    chk("R5", "Y holds old X", 112'(idx_y_o), 112'(16'hA1B2));
  endtask

  task automatic t_byte_moves();
    run_op(1'b0, 4'd8, 4'd3, 1'b0, "R6");           // A -> U
    chk("R6", "byte widened with FF", 112'(usp_o), 112'(16'hFF12));
    run_op(1'b0, 4'd1, 4'd10, 1'b0, "R6");          // X -> flags
    chk("R6", "byte takes low half", 112'(flags_o), 112'(8'hB2));
  endtask

  task automatic t_d_alias();
    run_op(1'b0, 4'd4, 4'd0, 1'b0, "R7");           // S -> D
    chk("R7", "D split into A:B", 112'({acc_a_o, acc_b_o}), 112'(16'h0718));
    run_op(1'b0, 4'd11, 4'd9, 1'b0, "R7");          // page -> B
    run_op(1'b0, 4'd0, 4'd5, 1'b0, "R7");           // D -> PC
    chk("R7", "D reads A:B after B write", 112'(pc_o), 112'(16'h0778));
  endtask

  task automatic t_exchange();
    run_op(1'b1, 4'd1, 4'd4, 1'b0, "R4");           // X <-> S
    chk("R4", "X/S swapped", 112'({idx_x_o, ssp_o}), 112'({16'h0718, 16'hA1B2}));
    run_op(1'b1, 4'd8, 4'd9, 1'b0, "R2");           // A <-> B, 8-bit pair
    chk("R2", "8-bit pair swapped", 112'({acc_a_o, acc_b_o}), 112'(16'h7807));
  endtask

  task automatic t_undefined();
    run_op(1'b0, 4'd6, 4'd2, 1'b0, "R8");           // undefined -> Y
    chk("R8", "undefined reads FFFF", 112'(idx_y_o), 112'(16'hFFFF));
    run_op(1'b0, 4'd3, 4'd13, 1'b0, "R8");          // U -> undefined
    run_op(1'b1, 4'd2, 4'd15, 1'b0, "R8");          // Y <-> undefined
    chk("R8", "Y takes FFFF from undefined", 112'(idx_y_o), 112'(16'hFFFF));
  endtask

  task automatic t_busy_start();
    run_op(1'b0, 4'd5, 4'd3, 1'b1, "R9");           // PC -> U with stray start
    chk("R9", "stray start had no effect on X", 112'(idx_x_o), 112'(16'h0718));
    run_op(1'b1, 4'd10, 4'd11, 1'b1, "R9");         // flags <-> page with stray start
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_wide_xfer();
    t_byte_moves();
    t_d_alias();
    t_exchange();
    t_undefined();
    t_busy_start();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog: act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule